// File: doc/BRIEF.md
# Prioritized PWM Fault Reporter

This block collects fault flags from a set of analog comparators, filters each one for a source-specific settling time, and latches it. It then tells a host controller about the latched faults one at a time over a single wired-AND line. The block encodes each fault as a pulse-width-modulated waveform whose high fraction identifies the source. After the last fault it sends a distinct end-of-frame waveform.

The host confirms each code by pulling the shared line low across one of the block's falling edges. The block then switches to the most urgent latched fault that has not yet gone out in this frame. When the host confirms the end-of-frame code, every latch clears and the line rests high. A sleep flag forces the line low and wipes the state. On wake the line simply returns high.

Fault indices, from most to least urgent: 0 drain-source, 1 regulator overvoltage, 2 pump-output undervoltage, 3 gate-source undervoltage, 4 regulator undervoltage, 5 overtemperature, 6 main-supply undervoltage, 7 main-supply overvoltage, 8 logic-supply undervoltage, 9 memory uncorrectable error. Code 10 is end-of-frame.

Top module: `prio_pwm_reporter`

## Requirements
- R1: After reset, and whenever no frame is in progress and sleep is low, `line_low` is 0 and `frame_pending` is 0.
- R2: A fault input latches only after it has been high on consecutive clocks for its filter count: DB_SHORT for indices 0, 1, 3, 5 and 7, DB_MID for 6 and 8, and DB_LONG for 2 and 4. Index 9 latches on a single high clock.
- R3: With its enable low, index 0 (`ds_chk_en`), index 1 (`reg_ov_chk_en`) or index 3 (`gs_uv_chk_en`) never latches. Index 7 has no enable and always latches.
- R4: Every PWM period starts with the line released. The released (high) time is period × d / 1000 clocks, rounded half up. Here d = 55 × (index + 1) for indices 0 to 8, d = 550 for index 9, and d = 935 for end-of-frame.
- R5: The period is PER_FAST clocks when `speed_fast` is 1 and PER_SLOW clocks when it is 0.
- R6: A frame starts with the lowest-index latched fault. Each code repeats until the host acknowledges it, and then the lowest-index latched fault not yet sent in this frame follows.
- R7: An acknowledge is counted only when `line_in` is low on the last clock of the released phase. A host hold that covers no such point has no effect. One continuous hold, even over several periods, counts once, because the line must be seen high again before the next acknowledge.
- R8: A fault that latches after the frame has started is sent after the current code, even if it has a lower index. Within one frame each fault is sent at most once, even if it stays active.
- R9: When every latched fault has been sent, the end-of-frame code follows. Acknowledging it clears all latches and ends the frame. A fault input that is still active starts a new frame.
- R10: While `sleep` is 1, `line_low` is 1 and all latches and frame state are cleared. After `sleep` falls, the line is released with no end-of-frame exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_raw | input | 10 | Raw comparator flags, bit = fault index |
| ds_chk_en | input | 1 | Enable for drain-source fault (index 0) |
| reg_ov_chk_en | input | 1 | Enable for regulator overvoltage (index 1) |
| gs_uv_chk_en | input | 1 | Enable for gate-source undervoltage (index 3) |
| speed_fast | input | 1 | 1 selects the short PWM period, 0 the long one |
| sleep | input | 1 | Forces the line low and clears all state |
| line_in | input | 1 | Sampled level of the shared line |
| line_low | output | 1 | 1 pulls the shared line low |
| frame_pending | output | 1 | A fault frame is being transmitted |

## Verification
Random fault sets drawn at once show whether the first code follows filter latency and the rest follow index order. Staggered directed faults show the late-arrival case, where a lower-index fault follows the code already in flight. Holds by the host that miss the falling point, or that last several periods, distinguish a true acknowledge from a level check or a repeated acknowledge. Short and long pulses per filter class, masked inputs, slow-period frames, a persistent fault across end-of-frame, and sleep in the middle of a frame cover the remaining boundaries.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int NSRC = 10;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_EOF = 4'd10;

  typedef enum logic { ST_IDLE, ST_SEND } frame_st_e;
  typedef enum logic [1:0] { DBC_NONE, DBC_SHORT, DBC_MID, DBC_LONG } db_class_e;

  // high fraction in thousandths for a code
  function automatic int code_permille(input logic [CODE_W-1:0] c);
    if (c < 4'd9) return 55 * (int'(c) + 1);
    else if (c == 4'd9) return 550;
    else return 935;
  endfunction

  // released time in clocks, rounded half up
  function automatic int hi_ticks(input int per, input int pm);
    return (per * pm + 500) / 1000;
  endfunction

  function automatic db_class_e db_class(input int idx);
    case (idx)
      0, 1, 3, 5, 7: return DBC_SHORT;
      6, 8:          return DBC_MID;
      2, 4:          return DBC_LONG;
      default:       return DBC_NONE;
    endcase
  endfunction

  // lowest set index, or end-of-frame when none
  function automatic logic [CODE_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [CODE_W-1:0] r;
    r = CODE_EOF;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = CODE_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/prd_debounce_bank.sv
module prd_debounce_bank
  import prd_pkg::*;
#(
  parameter int T_SHORT = 200,
  parameter int T_MID   = 800,
  parameter int T_LONG  = 1600
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] deb
);
  localparam int T_MAX = (T_LONG > T_MID) ? ((T_LONG > T_SHORT) ? T_LONG : T_SHORT)
                                          : ((T_MID > T_SHORT) ? T_MID : T_SHORT);
  localparam int CW = $clog2(T_MAX + 1);

  function automatic int lim_of(input int idx);
    case (db_class(idx))
      DBC_SHORT: return T_SHORT;
      DBC_MID:   return T_MID;
      DBC_LONG:  return T_LONG;
      default:   return 0;
    endcase
  endfunction

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int LIM = lim_of(i);
    if (LIM == 0) begin : g_direct
      assign deb[i] = raw[i];
    end else begin : g_cnt
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clr || !raw[i])    cnt_q <= '0;
        else if (cnt_q != CW'(LIM)) cnt_q <= cnt_q + 1'b1;
      end
      assign deb[i] = raw[i] && (cnt_q == CW'(LIM));
    end
  end
endmodule

// File: rtl/prd_latch_bank.sv
module prd_latch_bank
  import prd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NSRC-1:0] deb,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lat <= '0;
    else if (clr) lat <= '0;
    else          lat <= lat | (deb & en);
  end
endmodule

// File: rtl/prd_pwm_tx.sv
module prd_pwm_tx #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] hi,
  output logic             drive_low,
  output logic             fall_tick
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || restart)   cnt_q <= '0;
    else if (cnt_q >= per - ONE) cnt_q <= '0;
    else                        cnt_q <= cnt_q + ONE;
  end

  assign drive_low = run && (cnt_q >= hi);
  assign fall_tick = run && (cnt_q == hi - ONE);
endmodule

// File: rtl/prio_pwm_reporter.sv
module prio_pwm_reporter
  import prd_pkg::*;
#(
  parameter int PER_FAST   = 1000,
  parameter int PER_SLOW   = 6400,
  parameter int DB_SHORT   = 200,
  parameter int DB_MID     = 800,
  parameter int DB_LONG    = 1600
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] fault_raw,
  input  logic            ds_chk_en,
  input  logic            reg_ov_chk_en,
  input  logic            gs_uv_chk_en,
  input  logic            speed_fast,
  input  logic            sleep,
  input  logic            line_in,
  output logic            line_low,
  output logic            frame_pending
);
  localparam int PER_MAX = (PER_SLOW > PER_FAST) ? PER_SLOW : PER_FAST;
  localparam int CNT_W   = $clog2(PER_MAX + 1);

  logic [NSRC-1:0]   deb, lat, en_mask, sent_q, cur_oh, sent_upd;
  frame_st_e         st_q;
  logic [CODE_W-1:0] cur_q, next_code;
  logic              armed_q;
  logic [CNT_W-1:0]  per_sel, hi_sel;
  logic              pwm_low, fall_tick;
  logic              ack_ev, eof_ack, start_ev, run;

  always_comb begin
    en_mask    = '1;
    en_mask[0] = ds_chk_en;
    en_mask[1] = reg_ov_chk_en;
    en_mask[3] = gs_uv_chk_en;
  end

  prd_debounce_bank #(.T_SHORT(DB_SHORT), .T_MID(DB_MID), .T_LONG(DB_LONG)) u_deb (
    .clk(clk), .rst_n(rst_n), .clr(sleep), .raw(fault_raw), .deb(deb)
  );

  prd_latch_bank u_lat (
    .clk(clk), .rst_n(rst_n), .clr(sleep || eof_ack), .deb(deb), .en(en_mask), .lat(lat)
  );

  assign per_sel = speed_fast ? CNT_W'(PER_FAST) : CNT_W'(PER_SLOW);
  assign hi_sel  = CNT_W'(hi_ticks(32'(per_sel), code_permille(cur_q)));
  assign run     = (st_q == ST_SEND) && !sleep;

  prd_pwm_tx #(.CNT_W(CNT_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ack_ev),
    .per(per_sel), .hi(hi_sel), .drive_low(pwm_low), .fall_tick(fall_tick)
  );

  // named events for the frame logic and the checker
  assign ack_ev   = run && fall_tick && !line_in && armed_q;
  assign eof_ack  = ack_ev && (cur_q == CODE_EOF);
  assign start_ev = (st_q == ST_IDLE) && (|lat) && !sleep;

  always_comb begin
    for (int i = 0; i < NSRC; i++) cur_oh[i] = (cur_q == CODE_W'(i));
  end
  assign sent_upd  = sent_q | cur_oh;
  assign next_code = first_set(lat & ~sent_upd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= CODE_EOF;
      sent_q  <= '0;
      armed_q <= 1'b1;
    end else if (sleep) begin
      st_q    <= ST_IDLE;
      cur_q   <= CODE_EOF;
      sent_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      if (line_in) armed_q <= 1'b1;
      if (start_ev) begin
        st_q  <= ST_SEND;
        cur_q <= first_set(lat);
      end else if (ack_ev) begin
        armed_q <= 1'b0;
        if (cur_q == CODE_EOF) begin
          st_q   <= ST_IDLE;
          sent_q <= '0;
        end else begin
          sent_q <= sent_upd;
          cur_q  <= next_code;
        end
      end
    end
  end

  assign line_low      = sleep || pwm_low;
  assign frame_pending = (st_q == ST_SEND);
endmodule

// File: rtl/prd_reporter_chk.sv
module prd_reporter_chk
  import prd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              line_in,
  input logic              line_low,
  input logic              frame_pending,
  input logic              ack_ev,
  input logic              eof_ack,
  input logic [CODE_W-1:0] cur_code,
  input logic [NSRC-1:0]   sent
);
  logic [15:0] sent_ext;
  assign sent_ext = {{(16 - NSRC){1'b0}}, sent};

  AST_SLEEP_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> line_low); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_pending && !sleep) |-> !line_low); // R1
  AST_EOF_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    eof_ack |=> !frame_pending); // R9
  AST_ACK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ev |-> (!line_in && frame_pending)); // R7
  AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ev |=> !ack_ev); // R7
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pending && !ack_ev && !sleep) |=> $stable(cur_code)); // R6
  AST_NO_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && cur_code != CODE_EOF) |-> !sent_ext[cur_code]); // R8
endmodule

bind prio_pwm_reporter prd_reporter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .line_in(line_in), .line_low(line_low),
  .frame_pending(frame_pending), .ack_ev(ack_ev), .eof_ack(eof_ack),
  .cur_code(cur_q), .sent(sent_q)
);

// File: tb/tb_prio_pwm_reporter.sv
module tb_prio_pwm_reporter;
  localparam int PF = 100;
  localparam int PS = 200;
  localparam int TS = 4;
  localparam int TM = 12;
  localparam int TL = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, ds_en, ro_en, gs_en, fast, slp, host_low;
  logic [9:0] raw;
  wire        line_low, pend;
  wire        line_in = ~(line_low | host_low);

  prio_pwm_reporter #(.PER_FAST(PF), .PER_SLOW(PS), .DB_SHORT(TS), .DB_MID(TM), .DB_LONG(TL)) dut (
    .clk(clk), .rst_n(rst_n), .fault_raw(raw), .ds_chk_en(ds_en), .reg_ov_chk_en(ro_en),
    .gs_uv_chk_en(gs_en), .speed_fast(fast), .sleep(slp), .line_in(line_in),
    .line_low(line_low), .frame_pending(pend)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected released clocks: nearest integer of per*fraction, halves upward
  function automatic int exp_hi(input int per, input int code);
    int tenths;
    if (code <= 8) tenths = 55 * (code + 1);
    else if (code == 9) tenths = 550;
    else tenths = 935;
    return (2 * per * tenths + 1000) / 2000;
  endfunction

  function automatic int rank(input int i);
    if (i == 9) return 0;
    if (i == 6 || i == 8) return 2;
    if (i == 2 || i == 4) return 3;
    return 1;
  endfunction

  function automatic int first_code(input logic [9:0] m);
    int best = -1;
    for (int i = 0; i < 10; i++)
      if (m[i] && (best < 0 || rank(i) < rank(best))) best = i;
    return best;
  endfunction

  task automatic pulse(input logic [9:0] m, input int n);
    raw = m;
    repeat (n) @(negedge clk);
    raw = '0;
  endtask

  task automatic read_code(output int h, output int p);
    int l = 0;
    h = 0;
    while (line_low !== 1'b1) @(negedge clk);
    while (line_low !== 1'b0) @(negedge clk);
    while (line_low === 1'b0) begin h++; @(negedge clk); end
    while (line_low === 1'b1) begin l++; @(negedge clk); end
    p = h + l;
  endtask

  task automatic host_ack(input int per, input int halves);
    host_low = 1'b1;
    repeat (per * halves / 2) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic expect_code(input int code, input int per, input int halves, input string req);
    int h, p;
    read_code(h, p);
    chk(p == per, {req, " period"}, p, per);
    chk(h == exp_hi(per, code), {req, " high time"}, h, exp_hi(per, code));
    host_ack(per, halves);
  endtask

  task automatic expect_idle(input string req);
    chk(pend == 1'b0, {req, " frame_pending"}, pend, 0);
    chk(line_low == 1'b0, {req, " line_low"}, line_low, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h, p, cnt;
    rst_n = 1'b0; raw = '0; ds_en = 1'b1; ro_en = 1'b1; gs_en = 1'b1;
    fast = 1'b1; slp = 1'b0; host_low = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_idle("R1 reset");

    // R6/R4: simultaneous short-filter group plus a long one
    pulse(10'b00_0011_0010, 40);
    expect_code(1, PF, 3, "R6 first");
    expect_code(4, PF, 3, "R6 second");
    expect_code(5, PF, 3, "R4 third");
    expect_code(10, PF, 3, "R9 eof");
    expect_idle("R9 after eof");

    // R2: filter boundaries
    pulse(10'b00_0000_0100, TL - 12);
    repeat (10) @(negedge clk);
    expect_idle("R2 short pulse long class");
    pulse(10'b00_0000_0001, TS - 1);
    repeat (10) @(negedge clk);
    expect_idle("R2 short pulse short class");
    pulse(10'b00_0000_0100, TL + 8);
    expect_code(2, PF, 3, "R2 long class latched");
    expect_code(10, PF, 3, "R2 eof");
    pulse(10'b10_0000_0000, 1);
    expect_code(9, PF, 3, "R2 unfiltered index 9");
    expect_code(10, PF, 3, "R2 eof after 9");
    expect_idle("R2 idle");

    // R3: masks
    ds_en = 1'b0; ro_en = 1'b0; gs_en = 1'b0;
    pulse(10'b00_0000_1011, 40);
    repeat (10) @(negedge clk);
    expect_idle("R3 masked ignored");
    pulse(10'b00_1000_1001, 40);
    expect_code(7, PF, 3, "R3 main overvoltage unmaskable");
    expect_code(10, PF, 3, "R3 eof");
    expect_idle("R3 idle");
    ds_en = 1'b1; ro_en = 1'b1; gs_en = 1'b1;

    // R8: late lower-index fault goes after the code in flight
    pulse(10'b00_0010_0000, 40);
    pulse(10'b00_0000_0010, 40);
    expect_code(5, PF, 3, "R8 in flight");
    expect_code(1, PF, 3, "R8 late arrival");
    expect_code(10, PF, 3, "R8 eof");
    expect_idle("R8 idle");

    // R8/R9: persistent fault sent once per frame, restarts after eof
    raw = 10'b00_0100_1000;
    repeat (40) @(negedge clk);
    raw = 10'b00_0000_1000;
    expect_code(3, PF, 3, "R8 persistent first");
    expect_code(6, PF, 3, "R8 second");
    expect_code(10, PF, 3, "R8 no resend then eof");
    repeat (4) @(negedge clk);
    chk(pend == 1'b1, "R9 new frame for active fault", pend, 1);
    raw = '0;
    expect_code(3, PF, 3, "R9 new frame code");
    expect_code(10, PF, 3, "R9 eof");
    expect_idle("R9 idle");

    // R7: hold that misses the falling point, then a long hold
    pulse(10'b01_0000_0000, 40);
    read_code(h, p);
    chk(h == exp_hi(PF, 8), "R7 code before ack", h, exp_hi(PF, 8));
    repeat (exp_hi(PF, 8) + 5) @(negedge clk);
    host_low = 1'b1;
    repeat (10) @(negedge clk);
    host_low = 1'b0;
    expect_code(8, PF, 5, "R7 no ack from short hold");
    expect_code(10, PF, 3, "R7 single ack from long hold");
    expect_idle("R7 idle");

    // R5: slow period
    fast = 1'b0;
    pulse(10'b00_0100_0000, 40);
    expect_code(6, PS, 3, "R5 slow");
    expect_code(10, PS, 3, "R5 slow eof");
    expect_idle("R5 idle");
    fast = 1'b1;

    // R10: sleep in mid frame
    pulse(10'b00_0001_0000, 40);
    while (pend !== 1'b1) @(negedge clk);
    slp = 1'b1;
    @(negedge clk);
    chk(line_low == 1'b1, "R10 sleep drives low", line_low, 1);
    chk(pend == 1'b0, "R10 sleep clears frame", pend, 0);
    repeat (10) @(negedge clk);
    slp = 1'b0;
    @(negedge clk);
    expect_idle("R10 wake");
    cnt = 0;
    for (int i = 0; i < 3 * PF; i++) begin
      if (line_low !== 1'b0 || pend !== 1'b0) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R10 stays released without eof", cnt, 0);

    // random fault sets
    void'($urandom(32'd4711));
    for (int it = 0; it < 8; it++) begin
      logic [9:0] m;
      int f;
      m = 10'($urandom());
      if (m == '0) m = 10'b00_1000_0000;
      f = first_code(m);
      pulse(m, 40);
      expect_code(f, PF, 3, "R6 random first");
      for (int i = 0; i < 10; i++)
        if (m[i] && i != f) expect_code(i, PF, 3, "R6 random order");
      expect_code(10, PF, 3, "R9 random eof");
      expect_idle("R9 random idle");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule